// File: doc/BRIEF.md
# Root Clock Configuration Update Controller

This block is the register front end of a root clock generator. Software reaches it through a plain register bus. It writes a shadow copy of the clock configuration: source select, half-integer pre-divider code, counter mode, a hardware clock-control flag, and the three fractional counter values N, M and D. It then asks for that configuration to become live. The controller moves the shadow values into the active configuration that drives the divider datapath. It waits a short synchronisation interval first. If the root is running, it also waits for a boundary of the output clock, so the datapath never sees a half-updated setting. When the move is done it clears the request bit itself, and software polls for that.

The controller also tracks which shadow registers have changed since the last transfer, and it copies only those. A force-enable bit keeps the root running while it is reconfigured. A consumer request input does the same. A root-off status flag reports whether the root has actually come up, and it clears a fixed number of cycles after the root is asked to run. A parking sequence needs no extra hardware. Software forces the root on, writes a safe source with the divider fields cleared, commits, and releases the force-enable.

Top module: `clkgen_cfg_ctrl`

## Requirements
- R1: After reset the control register (address 0) reads 0x8000_0000, with only the root-off flag set. Every shadow register reads 0, `root_en_o` is 0 and every active output is 0.
- R2: A write to the configuration register (address 1) sets dirty bit 4 of the control register. A write to N (address 2) sets bit 5, M (address 3) sets bit 6 and D (address 4) sets bit 7. None of these writes changes an active output.
- R3: The configuration register holds the pre-divider code in bits [HID_W-1:0], the source select in bits [10:8], the mode in bits [13:12] and the hardware clock-control flag in bit 20. All other bits read 0. N, M and D hold their low MND_W bits and read 0 above them.
- R4: Writing 1 to control bit 0 sets the update request, and it reads back 1. It stays 1 for at least SYNC_CYC+1 cycles and then clears itself in the cycle the configuration is committed.
- R5: While the root is running (root-off flag 0), the commit waits for a pulse on `out_edge_i` that arrives after the synchronisation interval. The active outputs change only at that edge. A pulse during the synchronisation interval has no effect.
- R6: While the root is off, the commit happens in the first cycle after the synchronisation interval, with no edge pulse. With SYNC_CYC=2 the request bit reads 1 for exactly 3 cycles.
- R7: A commit copies every dirty shadow register to the matching active output and clears all four dirty bits.
- R8: While the update request is pending, writes to addresses 1 to 4 are ignored, and a second update request is ignored.
- R9: Control bit 1 is the force-enable, and it reads back as written. `root_en_o` is 1 one cycle after the force-enable or `clk_req_i` is seen high. The root-off flag (control bit 31) reads 1 for the first ON_LAT cycles of such a request and 0 from the next cycle on. It returns to 1 one cycle after both requests are low.
- R10: The parking sequence ends with the safe source active, the pre-divider and mode at 0, and the root off again once the force-enable is released.
- R11: Writing 0 to control bit 0 starts no update. Writes to addresses 5 to 7 change nothing, and those addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| clk_req_i | input | 1 | Consumer request to run the root |
| out_edge_i | input | 1 | One-cycle marker of an output clock boundary from the datapath |
| root_en_o | output | 1 | Root run enable toward the datapath |
| act_src_o | output | 3 | Active source select |
| act_div_o | output | HID_W | Active pre-divider code |
| act_mode_o | output | 2 | Active counter mode |
| act_hwc_o | output | 1 | Active hardware clock-control flag |
| act_n_o | output | MND_W | Active N value |
| act_m_o | output | MND_W | Active M value |
| act_d_o | output | MND_W | Active D value |

## Verification
The bench builds the block with HID_W=5, MND_W=8, SYNC_CYC=2 and ON_LAT=3. With a 5-bit divider code, the sweep over all 8 sources and 4 modes writes every pre-divider code exactly once. Each of these writes goes through a full commit with the root off. A short ON_LAT makes it cheap to check the exact cycle the root-off flag clears. With SYNC_CYC=2, the bench can test an edge pulse that arrives too early. It can also test shadow writes that are dropped while a request is pending.

// File: rtl/ccu_pkg.sv
package ccu_pkg;
  // register addresses
  localparam logic [2:0] A_CTL  = 3'd0;
  localparam logic [2:0] A_CFG  = 3'd1;
  localparam logic [2:0] A_NVAL = 3'd2;
  localparam logic [2:0] A_MVAL = 3'd3;
  localparam logic [2:0] A_DVAL = 3'd4;

  // control register bits
  localparam int B_UPD   = 0;
  localparam int B_FORCE = 1;
  localparam int B_DIRTY = 4;   // four flags: cfg, N, M, D
  localparam int B_OFF   = 31;

  // configuration register fields
  localparam int SRC_LSB  = 8;
  localparam int MODE_LSB = 12;
  localparam int HWC_BIT  = 20;

  // dirty vector index
  localparam int DI_CFG = 0;    // N, M, D follow at 1..3

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_SYNC  = 2'd1,
    SQ_ALIGN = 2'd2
  } seq_st_e;
endpackage

// File: rtl/ccu_shadow.sv
module ccu_shadow
  import ccu_pkg::*;
#(
  parameter int HID_W = 5,
  parameter int MND_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_ok,
  input  logic [2:0]            addr,
  input  logic [HID_W-1:0]      w_div,
  input  logic [2:0]            w_src,
  input  logic [1:0]            w_mode,
  input  logic                  w_hwc,
  input  logic [MND_W-1:0]      w_val,
  input  logic                  commit,
  output logic [HID_W-1:0]      sh_div,
  output logic [2:0]            sh_src,
  output logic [1:0]            sh_mode,
  output logic                  sh_hwc,
  output logic [2:0][MND_W-1:0] sh_mnd,
  output logic [3:0]            dirty
);
  logic [HID_W-1:0] div_q, div_d;
  logic [2:0]       src_q, src_d;
  logic [1:0]       mode_q, mode_d;
  logic             hwc_q, hwc_d;
  logic             cdirty_q, cdirty_d;
  logic             cfg_wr;

  assign cfg_wr = wr_ok && (addr == A_CFG);

  always_comb begin
    div_d    = div_q;
    src_d    = src_q;
    mode_d   = mode_q;
    hwc_d    = hwc_q;
    cdirty_d = cdirty_q;
    if (commit) cdirty_d = 1'b0;
    if (cfg_wr) begin
      div_d    = w_div;
      src_d    = w_src;
      mode_d   = w_mode;
      hwc_d    = w_hwc;
      cdirty_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q    <= '0;
      src_q    <= '0;
      mode_q   <= '0;
      hwc_q    <= 1'b0;
      cdirty_q <= 1'b0;
    end else begin
      div_q    <= div_d;
      src_q    <= src_d;
      mode_q   <= mode_d;
      hwc_q    <= hwc_d;
      cdirty_q <= cdirty_d;
    end
  end

  assign sh_div       = div_q;
  assign sh_src       = src_q;
  assign sh_mode      = mode_q;
  assign sh_hwc       = hwc_q;
  assign dirty[DI_CFG] = cdirty_q;

  // N, M, D share one structure, addresses A_NVAL + g
  for (genvar g = 0; g < 3; g++) begin : g_val
    localparam logic [2:0] MY_ADDR = A_NVAL + 3'(g);
    logic [MND_W-1:0] val_q, val_d;
    logic             dq, dd;
    logic             hit;

    assign hit = wr_ok && (addr == MY_ADDR);

    always_comb begin
      val_d = val_q;
      dd    = dq;
      if (commit) dd = 1'b0;
      if (hit) begin
        val_d = w_val;
        dd    = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q <= '0;
        dq    <= 1'b0;
      end else begin
        val_q <= val_d;
        dq    <= dd;
      end
    end

    assign sh_mnd[g]  = val_q;
    assign dirty[g+1] = dq;
  end
endmodule

// File: rtl/ccu_active.sv
module ccu_active #(
  parameter int HID_W = 5,
  parameter int MND_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  commit,
  input  logic [3:0]            dirty,
  input  logic [HID_W-1:0]      sh_div,
  input  logic [2:0]            sh_src,
  input  logic [1:0]            sh_mode,
  input  logic                  sh_hwc,
  input  logic [2:0][MND_W-1:0] sh_mnd,
  output logic [HID_W-1:0]      act_div,
  output logic [2:0]            act_src,
  output logic [1:0]            act_mode,
  output logic                  act_hwc,
  output logic [2:0][MND_W-1:0] act_mnd
);
  logic [HID_W-1:0] div_q;
  logic [2:0]       src_q;
  logic [1:0]       mode_q;
  logic             hwc_q;
  logic             cfg_en;

  // clock enable: only dirty registers are transferred
  assign cfg_en = commit && dirty[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      src_q  <= '0;
      mode_q <= '0;
      hwc_q  <= 1'b0;
    end else if (cfg_en) begin
      div_q  <= sh_div;
      src_q  <= sh_src;
      mode_q <= sh_mode;
      hwc_q  <= sh_hwc;
    end
  end

  assign act_div  = div_q;
  assign act_src  = src_q;
  assign act_mode = mode_q;
  assign act_hwc  = hwc_q;

  for (genvar g = 0; g < 3; g++) begin : g_val
    logic [MND_W-1:0] val_q;
    logic             en;
    assign en = commit && dirty[g+1];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  val_q <= '0;
      else if (en) val_q <= sh_mnd[g];
    end
    assign act_mnd[g] = val_q;
  end
endmodule

// File: rtl/ccu_seq.sv
module ccu_seq
  import ccu_pkg::*;
#(
  parameter int SYNC_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic root_off,
  input  logic out_edge,
  output logic busy,
  output logic commit
);
  localparam int CW = (SYNC_CYC < 2) ? 1 : $clog2(SYNC_CYC);

  seq_st_e       st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;

  // a stopped root has no boundary to wait for
  assign commit = (st_q == SQ_ALIGN) && (out_edge || root_off);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      SQ_IDLE: begin
        if (start) begin
          st_d  = SQ_SYNC;
          cnt_d = '0;
        end
      end
      SQ_SYNC: begin
        if (cnt_q == CW'(SYNC_CYC - 1)) st_d = SQ_ALIGN;
        else                            cnt_d = cnt_q + 1'b1;
      end
      SQ_ALIGN: begin
        if (commit) st_d = SQ_IDLE;
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign busy = (st_q != SQ_IDLE);
endmodule

// File: rtl/ccu_root.sv
module ccu_root #(
  parameter int ON_LAT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic force_en,
  input  logic clk_req,
  output logic root_en,
  output logic root_off
);
  localparam int CW = $clog2(ON_LAT + 1);

  logic          req;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          off_d, en_d;
  logic          en_q, off_q;

  assign req = force_en || clk_req;

  always_comb begin
    en_d  = req;
    off_d = !(req && (cnt_q == CW'(ON_LAT)));
    if (!req)                       cnt_d = '0;
    else if (cnt_q == CW'(ON_LAT))  cnt_d = cnt_q;
    else                            cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
      off_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      en_q  <= en_d;
      off_q <= off_d;
    end
  end

  assign root_en  = en_q;
  assign root_off = off_q;
endmodule

// File: rtl/clkgen_cfg_ctrl.sv
module clkgen_cfg_ctrl
  import ccu_pkg::*;
#(
  parameter int HID_W    = 5,
  parameter int MND_W    = 8,
  parameter int SYNC_CYC = 2,
  parameter int ON_LAT   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [2:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic             clk_req_i,
  input  logic             out_edge_i,
  output logic             root_en_o,
  output logic [2:0]       act_src_o,
  output logic [HID_W-1:0] act_div_o,
  output logic [1:0]       act_mode_o,
  output logic             act_hwc_o,
  output logic [MND_W-1:0] act_n_o,
  output logic [MND_W-1:0] act_m_o,
  output logic [MND_W-1:0] act_d_o
);
  logic                  busy, commit, root_off;
  logic                  ctl_wr, start, wr_ok;
  logic                  force_q, force_d;
  logic [3:0]            dirty;
  logic [HID_W-1:0]      sh_div;
  logic [2:0]            sh_src;
  logic [1:0]            sh_mode;
  logic                  sh_hwc;
  logic [2:0][MND_W-1:0] sh_mnd;
  logic [2:0][MND_W-1:0] act_mnd;
  logic                  unused_wdata;

  assign unused_wdata = ^bus_wdata;

  assign ctl_wr = bus_wr && (bus_addr == A_CTL);
  assign start  = ctl_wr && bus_wdata[B_UPD] && !busy;
  assign wr_ok  = bus_wr && !busy;

  always_comb begin
    force_d = force_q;
    if (ctl_wr) force_d = bus_wdata[B_FORCE];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) force_q <= 1'b0;
    else        force_q <= force_d;
  end

  ccu_shadow #(.HID_W(HID_W), .MND_W(MND_W)) u_shadow (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_ok  (wr_ok),
    .addr   (bus_addr),
    .w_div  (bus_wdata[HID_W-1:0]),
    .w_src  (bus_wdata[SRC_LSB +: 3]),
    .w_mode (bus_wdata[MODE_LSB +: 2]),
    .w_hwc  (bus_wdata[HWC_BIT]),
    .w_val  (bus_wdata[MND_W-1:0]),
    .commit (commit),
    .sh_div (sh_div),
    .sh_src (sh_src),
    .sh_mode(sh_mode),
    .sh_hwc (sh_hwc),
    .sh_mnd (sh_mnd),
    .dirty  (dirty)
  );

  ccu_seq #(.SYNC_CYC(SYNC_CYC)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .root_off(root_off),
    .out_edge(out_edge_i),
    .busy    (busy),
    .commit  (commit)
  );

  ccu_root #(.ON_LAT(ON_LAT)) u_root (
    .clk     (clk),
    .rst_n   (rst_n),
    .force_en(force_q),
    .clk_req (clk_req_i),
    .root_en (root_en_o),
    .root_off(root_off)
  );

  ccu_active #(.HID_W(HID_W), .MND_W(MND_W)) u_active (
    .clk     (clk),
    .rst_n   (rst_n),
    .commit  (commit),
    .dirty   (dirty),
    .sh_div  (sh_div),
    .sh_src  (sh_src),
    .sh_mode (sh_mode),
    .sh_hwc  (sh_hwc),
    .sh_mnd  (sh_mnd),
    .act_div (act_div_o),
    .act_src (act_src_o),
    .act_mode(act_mode_o),
    .act_hwc (act_hwc_o),
    .act_mnd (act_mnd)
  );

  assign act_n_o = act_mnd[0];
  assign act_m_o = act_mnd[1];
  assign act_d_o = act_mnd[2];

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTL: begin
        bus_rdata[B_UPD]          = busy;
        bus_rdata[B_FORCE]        = force_q;
        bus_rdata[B_DIRTY +: 4]   = dirty;
        bus_rdata[B_OFF]          = root_off;
      end
      A_CFG: begin
        bus_rdata[HID_W-1:0]      = sh_div;
        bus_rdata[SRC_LSB +: 3]   = sh_src;
        bus_rdata[MODE_LSB +: 2]  = sh_mode;
        bus_rdata[HWC_BIT]        = sh_hwc;
      end
      A_NVAL:  bus_rdata[MND_W-1:0] = sh_mnd[0];
      A_MVAL:  bus_rdata[MND_W-1:0] = sh_mnd[1];
      A_DVAL:  bus_rdata[MND_W-1:0] = sh_mnd[2];
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ccu_checker.sv
module ccu_checker
  import ccu_pkg::*;
#(
  parameter int HID_W  = 5,
  parameter int MND_W  = 8,
  parameter int ON_LAT = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_wr,
  input logic [2:0]            bus_addr,
  input logic                  out_edge_i,
  input logic                  busy,
  input logic                  root_off,
  input logic                  root_en_o,
  input logic [3:0]            dirty,
  input logic [HID_W-1:0]      sh_div,
  input logic [2:0]            sh_src,
  input logic [1:0]            sh_mode,
  input logic                  sh_hwc,
  input logic [2:0][MND_W-1:0] sh_mnd,
  input logic [HID_W-1:0]      act_div,
  input logic [2:0]            act_src,
  input logic [1:0]            act_mode,
  input logic                  act_hwc,
  input logic [2:0][MND_W-1:0] act_mnd
);
  localparam int WW = $clog2(ON_LAT + 2) + 1;

  logic [HID_W+6+3*MND_W-1:0] act_word, sh_word;
  logic [WW-1:0]              wait_cnt;

  assign act_word = {act_div, act_src, act_mode, act_hwc, act_mnd};
  assign sh_word  = {sh_div, sh_src, sh_mode, sh_hwc, sh_mnd};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       wait_cnt <= '0;
    else if (root_en_o && root_off)   wait_cnt <= wait_cnt + 1'b1;
    else                              wait_cnt <= '0;
  end

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(busy) && $past(busy, 2)));

  assert_edge_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_word) |-> ($past(out_edge_i) || $past(root_off)));

  assert_dirty_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (dirty == 4'b0000));

  assert_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && busy && (bus_addr != A_CTL)) |=> $stable(sh_word));

  assert_wake_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wait_cnt <= WW'(ON_LAT));

  assert_off_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !root_en_o |-> root_off);
endmodule

bind clkgen_cfg_ctrl ccu_checker #(
  .HID_W (HID_W),
  .MND_W (MND_W),
  .ON_LAT(ON_LAT)
) u_ccu_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .out_edge_i(out_edge_i),
  .busy      (busy),
  .root_off  (root_off),
  .root_en_o (root_en_o),
  .dirty     (dirty),
  .sh_div    (sh_div),
  .sh_src    (sh_src),
  .sh_mode   (sh_mode),
  .sh_hwc    (sh_hwc),
  .sh_mnd    (sh_mnd),
  .act_div   (act_div_o),
  .act_src   (act_src_o),
  .act_mode  (act_mode_o),
  .act_hwc   (act_hwc_o),
  .act_mnd   (act_mnd)
);

// File: tb/test_clkgen_cfg_ctrl.sv
`timescale 1ns/1ps
module test_clkgen_cfg_ctrl;
  localparam int HID_W    = 5;
  localparam int MND_W    = 8;
  localparam int SYNC_CYC = 2;
  localparam int ON_LAT   = 3;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             bus_wr;
  logic [2:0]       bus_addr;
  logic [31:0]      bus_wdata;
  logic [31:0]      bus_rdata;
  logic             clk_req_i;
  logic             out_edge_i;
  logic             root_en_o;
  logic [2:0]       act_src_o;
  logic [HID_W-1:0] act_div_o;
  logic [1:0]       act_mode_o;
  logic             act_hwc_o;
  logic [MND_W-1:0] act_n_o, act_m_o, act_d_o;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  clkgen_cfg_ctrl #(
    .HID_W(HID_W), .MND_W(MND_W), .SYNC_CYC(SYNC_CYC), .ON_LAT(ON_LAT)
  ) i_clkgen_cfg_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .clk_req_i(clk_req_i),
    .out_edge_i(out_edge_i), .root_en_o(root_en_o), .act_src_o(act_src_o),
    .act_div_o(act_div_o), .act_mode_o(act_mode_o), .act_hwc_o(act_hwc_o),
    .act_n_o(act_n_o), .act_m_o(act_m_o), .act_d_o(act_d_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] cfg_word(input int div, input int src, input int mode, input int hwc);
    return 32'(div) | (32'(src) << 8) | (32'(mode) << 12) | (32'(hwc) << 20);
  endfunction

  function automatic logic [31:0] act_cfg();
    return cfg_word(int'(act_div_o), int'(act_src_o), int'(act_mode_o), int'(act_hwc_o));
  endfunction

  // update with root off: busy for SYNC_CYC+1 cycles, then clear
  task automatic commit_off(input string req);
    logic [31:0] r;
    wr(3'd0, 32'h1);
    for (int k = 0; k <= SYNC_CYC; k++) begin
      rd(3'd0, r);
      check(req, {31'b0, r[0]}, 32'h1);
      @(negedge clk);
    end
    rd(3'd0, r);
    check(req, {31'b0, r[0]}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [31:0] prev;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    clk_req_i = 1'b0; out_edge_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, r); check("R1 ctl", r, 32'h8000_0000);
    for (int a = 1; a <= 4; a++) begin
      rd(3'(a), r); check("R1 shadow", r, 32'h0);
    end
    check("R1 root_en", {31'b0, root_en_o}, 32'h0);
    check("R1 act", act_cfg() | {act_n_o, act_m_o, act_d_o}, 32'h0);

    // R11 ignored writes
    wr(3'd0, 32'h0);
    rd(3'd0, r); check("R11 no update", r, 32'h8000_0000);
    for (int a = 5; a <= 7; a++) begin
      wr(3'(a), 32'hFFFF_FFFF);
      rd(3'(a), r); check("R11 unmapped read", r, 32'h0);
    end
    rd(3'd0, r); check("R11 no dirty", r, 32'h8000_0000);
    rd(3'd1, r); check("R11 cfg untouched", r, 32'h0);

    // R2 R3 R6 R7 sweep: all sources x modes, every divider code
    for (int s = 0; s < 8; s++) begin
      for (int m = 0; m < 4; m++) begin
        int dv = s * 4 + m;
        int hw = (s + m) % 2;
        prev = act_cfg();
        wr(3'd1, cfg_word(dv, s, m, hw) | 32'hFFE0_C8E0);
        rd(3'd1, r); check("R3 cfg fields", r, cfg_word(dv, s, m, hw));
        rd(3'd0, r); check("R2 cfg dirty", r, 32'h8000_0010);
        check("R2 act held", act_cfg(), prev);
        commit_off("R6 off commit");
        check("R7 act cfg", act_cfg(), cfg_word(dv, s, m, hw));
        rd(3'd0, r); check("R7 dirty clear", r, 32'h8000_0000);
      end
    end

    // R2 R3 R7 N/M/D sweep
    for (int v = 0; v < 16; v++) begin
      logic [7:0] nv, mv, dv;
      nv = 8'(v * 17); mv = 8'(v * 5 + 1); dv = 8'(255 - v * 9);
      wr(3'd2, 32'hABCD_0000 | 32'(nv));
      rd(3'd0, r); check("R2 N dirty", r, 32'h8000_0020);
      wr(3'd3, 32'h1234_5600 | 32'(mv));
      rd(3'd0, r); check("R2 M dirty", r, 32'h8000_0060);
      wr(3'd4, 32'hFFFF_FF00 | 32'(dv));
      rd(3'd0, r); check("R2 D dirty", r, 32'h8000_00E0);
      rd(3'd2, r); check("R3 N width", r, 32'(nv));
      rd(3'd3, r); check("R3 M width", r, 32'(mv));
      commit_off("R4 request hold");
      check("R7 act N", 32'(act_n_o), 32'(nv));
      check("R7 act M", 32'(act_m_o), 32'(mv));
      check("R7 act D", 32'(act_d_o), 32'(dv));
    end

    // R9 wake timing from consumer request
    clk_req_i = 1'b1;
    for (int k = 0; k < ON_LAT; k++) begin
      @(negedge clk);
      rd(3'd0, r); check("R9 off during wake", {31'b0, r[31]}, 32'h1);
      check("R9 root_en", {31'b0, root_en_o}, 32'h1);
    end
    @(negedge clk);
    rd(3'd0, r); check("R9 off cleared", {31'b0, r[31]}, 32'h0);

    // R5 running root waits for boundary; R8 locked writes
    wr(3'd1, cfg_word(9, 3, 2, 1));
    prev = act_cfg();
    wr(3'd0, 32'h1);
    out_edge_i = 1'b1;              // early pulse during sync
    wr(3'd1, cfg_word(1, 1, 1, 0));   // dropped
    out_edge_i = 1'b0;
    wr(3'd0, 32'h1);                 // second request ignored
    rd(3'd1, r); check("R8 shadow locked", r, cfg_word(9, 3, 2, 1));
    repeat (6) @(negedge clk);
    rd(3'd0, r); check("R5 still pending", {31'b0, r[0]}, 32'h1);
    check("R5 act held", act_cfg(), prev);
    out_edge_i = 1'b1;
    @(negedge clk);
    out_edge_i = 1'b0;
    rd(3'd0, r); check("R5 done at edge", {31'b0, r[0]}, 32'h0);
    check("R5 act at edge", act_cfg(), cfg_word(9, 3, 2, 1));

    // R9 drop
    clk_req_i = 1'b0;
    @(negedge clk);
    rd(3'd0, r); check("R9 off after drop", {31'b0, r[31]}, 32'h1);
    check("R9 en after drop", {31'b0, root_en_o}, 32'h0);

    // R10 parking sequence with force-enable
    wr(3'd0, 32'h2);
    rd(3'd0, r); check("R9 force readback", {30'b0, r[1:0]}, 32'h2);
    for (int k = 0; k < ON_LAT; k++) begin
      @(negedge clk);
      rd(3'd0, r); check("R9 forced wake", {31'b0, r[31]}, 32'h1);
    end
    @(negedge clk);
    rd(3'd0, r); check("R9 forced on", {31'b0, r[31]}, 32'h0);
    wr(3'd1, cfg_word(0, 5, 0, 0));
    wr(3'd0, 32'h3);
    repeat (SYNC_CYC + 2) @(negedge clk);
    out_edge_i = 1'b1;
    @(negedge clk);
    out_edge_i = 1'b0;
    rd(3'd0, r); check("R10 committed", {31'b0, r[0]}, 32'h0);
    check("R10 safe active", act_cfg(), cfg_word(0, 5, 0, 0));
    wr(3'd0, 32'h0);
    @(negedge clk);
    rd(3'd0, r); check("R10 parked off", r, 32'h8000_0000);
    check("R10 en low", {31'b0, root_en_o}, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule